// File: doc/BRIEF.md
# Palette DAC Host Register Interface

This block is the byte-wide register file that a host processor sees when it programs a palette DAC. A 4-bit offset, a write strobe and a read strobe reach sixteen directly decoded locations. Through these the host loads the palette and the cursor colours one byte at a time, sets the pixel read mask, and programs the control registers that steer the pixel and cursor logic. A fourth control register has no offset of its own. It shares the status location and is reached only when a gate bit is set and the palette write pointer holds 0x01.

Palette traffic goes through a single data port. A phase counter steps through the red, green and blue bytes. When the blue byte is written, the block issues one 24-bit write to the external palette RAM and advances the pointer. Reads through the same port walk the entries in the same way, using a separate read pointer and reading the palette RAM combinationally. Cursor colours use the same scheme, with a pair of index registers and four colours held inside the block. Read data is registered: it appears one cycle after the read strobe and is held until the next read.

Top module: `dac_host_regs`

## Requirements
- R1: After a synchronous active-low reset, control registers 0 to 3 read 0, the pixel mask reads 0xFF, and the palette pointers, cursor indices and phase counters are 0.
- R2: Writing offset 0x0 loads the palette write pointer. The next three writes to offset 0x1 are taken as red, green and blue. The blue write drives `pal_we` for that cycle with `pal_wdata` = {red, green, blue} at the pointer. The pointer then advances by one and wraps from 0xFF to 0x00. Reading offset 0x0 returns the pointer.
- R3: Writing offset 0x0 after one or two colour bytes discards those bytes and restarts the phase at red. No palette write happens for the partial triplet.
- R4: Writing offset 0x3 loads the read pointer and restarts its phase. Successive reads of offset 0x1 return red, green and blue of that entry, then continue with the next entry.
- R5: When a read and a write hit the same offset in one cycle, the read returns the state before the write, and the side effects of both take place. A pointer load wins over a read-phase advance.
- R6: Control registers 0, 1 and 2 (offsets 0x6, 0x8, 0x9) and the pixel mask (0x2) read back the last value written, so single fields can be changed by read-modify-write.
- R7: While bit 7 of control 0 is set and the write pointer equals 0x01, offset 0xA reads and writes control register 3.
- R8: Outside that condition, writes to offset 0xA are ignored. Reads of 0xA return status: the palette read phase (0 to 2) in bits 1:0, zeros above.
- R9: Control 3 bit 3 drives `clk_double`, bit 2 drives `cursor_64` (clear means 32x32), and bit 4 drives `nib_swap`.
- R10: Writing offset 0x4 loads the cursor colour write index (bits 1:0) and restarts the phase. Writes to 0x5 fill red, green and blue of that colour, then move to the next colour, wrapping from 3 to 0. Colour k appears on `cur_colors[24k+23:24k]` as {R,G,B}.
- R11: Writing offset 0x7 loads the cursor colour read index. Reads of 0x5 return that colour's red, green and blue, then move on to the next colour.
- R12: Offsets 0xC/0xD form `cur_x` = {0xD bits 3:0, 0xC} and offsets 0xE/0xF form `cur_y` in the same way. Reads of the high offsets return the stored nibble with zeros above it.
- R13: A write to offset 0xB drives `cram_we` in that same cycle, with `cram_wdata` equal to the written byte. No other offset raises `cram_we`.
- R14: `rd_data` updates on the clock edge where `rd_en` is high and holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| pal_we | output | 1 | Palette RAM write enable |
| pal_waddr | output | 8 | Palette write pointer / RAM write address |
| pal_wdata | output | 24 | Palette RAM write entry {R,G,B} |
| pal_raddr | output | 8 | Palette read pointer / RAM read address |
| pal_rdata | input | 24 | Palette RAM read entry, combinational |
| ctrl0 | output | 8 | Control register 0 |
| ctrl1 | output | 8 | Control register 1 |
| ctrl2 | output | 8 | Control register 2 |
| ctrl3 | output | 8 | Control register 3 |
| pix_mask | output | 8 | Pixel read mask |
| clk_double | output | 1 | Clock doubling select |
| cursor_64 | output | 1 | 64x64 cursor select |
| nib_swap | output | 1 | 4bpp nibble swap select |
| cur_colors | output | 96 | Four cursor colours, {R,G,B} each |
| cur_x | output | 12 | Cursor X position |
| cur_y | output | 12 | Cursor Y position |
| cram_we | output | 1 | Cursor RAM byte write strobe |
| cram_wdata | output | 8 | Cursor RAM byte |

## Verification
The palette data port serves both a write stream and a read stream. These run on separate pointers and phase counters, so a write to offset 0x1 and a read of offset 0x1 can land in the same cycle. The bench provokes this by raising both strobes on the data port once the write and read pointers point at the same entry. The returned byte must be the entry's old red value. The write must still count as the red byte of a triplet that later completes and becomes visible to the next read. The bench also loads the read pointer in the same cycle as a read of it, and checks that the old pointer is returned and that the new pointer starts at red.

// File: rtl/dac_host_pkg.sv
// Shared definitions for the palette DAC host register interface.
// Offsets are fixed because host software decodes them; nothing else here
// depends on the surrounding chip.
package dac_host_pkg;

    typedef enum logic [3:0] {
        OFF_PAL_WPTR = 4'h0,
        OFF_PAL_DATA = 4'h1,
        OFF_PIX_MASK = 4'h2,
        OFF_PAL_RPTR = 4'h3,
        OFF_CUR_WIDX = 4'h4,
        OFF_CUR_DATA = 4'h5,
        OFF_CTRL0    = 4'h6,
        OFF_CUR_RIDX = 4'h7,
        OFF_CTRL1    = 4'h8,
        OFF_CTRL2    = 4'h9,
        OFF_STAT_EXT = 4'hA,
        OFF_CRAM     = 4'hB,
        OFF_CX_LO    = 4'hC,
        OFF_CX_HI    = 4'hD,
        OFF_CY_LO    = 4'hE,
        OFF_CY_HI    = 4'hF
    } reg_off_e;

    // colour byte phase: 0 red, 1 green, 2 blue
    typedef logic [1:0] phase_t;
    localparam phase_t PH_LAST = 2'd2;

    // control 0 bit that opens the shared status location
    localparam int EXT_GATE_BIT = 7;
    // write-pointer value that selects control 3 behind the gate
    localparam int EXT_PTR_VAL  = 1;

    // control 3 field positions
    localparam int C3_NIBSWAP_BIT = 4;
    localparam int C3_CLKDBL_BIT  = 3;
    localparam int C3_CUR64_BIT   = 2;

endpackage

// File: rtl/dac_pal_port.sv
// Palette data port sequencer.
// Keeps independent write and read pointers, each with its own RGB phase.
// Assumes at most one load and one data access per pointer per cycle; a load
// takes priority over the data-access advance. The palette RAM read is
// assumed combinational from ram_raddr.
module dac_pal_port
    import dac_host_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_wptr,
    input  logic            load_rptr,
    input  logic            data_wr,
    input  logic            data_rd,
    input  logic [DW-1:0]   din,
    input  logic [3*DW-1:0] ram_rdata,
    output logic [AW-1:0]   wptr,
    output logic [AW-1:0]   rptr,
    output phase_t          rphase,
    output logic            ram_we,
    output logic [3*DW-1:0] ram_wdata,
    output logic [DW-1:0]   rd_byte
);

    phase_t          wphase;
    logic [DW-1:0]   hold_r;
    logic [DW-1:0]   hold_g;

    // write pointer and phase: load restarts, blue byte advances
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            wphase <= '0;
        end else if (load_wptr) begin
            wptr   <= din[AW-1:0];
            wphase <= '0;
        end else if (data_wr) begin
            if (wphase == PH_LAST) begin
                wphase <= '0;
                wptr   <= wptr + 1'b1;
            end else begin
                wphase <= wphase + 1'b1;
            end
        end
    end

    // capture red and green until the blue byte completes the entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_r <= '0;
            hold_g <= '0;
        end else if (data_wr && !load_wptr) begin
            if (wphase == 2'd0) hold_r <= din;
            if (wphase == 2'd1) hold_g <= din;
        end
    end

    // palette RAM write on the blue byte
    assign ram_we    = data_wr && (wphase == PH_LAST);
    assign ram_wdata = {hold_r, hold_g, din};

    // read pointer and phase: load wins over read advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr   <= '0;
            rphase <= '0;
        end else if (load_rptr) begin
            rptr   <= din[AW-1:0];
            rphase <= '0;
        end else if (data_rd) begin
            if (rphase == PH_LAST) begin
                rphase <= '0;
                rptr   <= rptr + 1'b1;
            end else begin
                rphase <= rphase + 1'b1;
            end
        end
    end

    // pick the colour byte for the current read phase
    always_comb begin
        case (rphase)
            2'd0:    rd_byte = ram_rdata[3*DW-1:2*DW];
            2'd1:    rd_byte = ram_rdata[2*DW-1:DW];
            default: rd_byte = ram_rdata[DW-1:0];
        endcase
    end

endmodule

// File: rtl/dac_cur_port.sv
// Cursor colour store with byte-serial write and read sequencing.
// Holds NCOL colours of three bytes each. Index registers advance after
// the blue byte and wrap; NCOL is assumed to be a power of two.
module dac_cur_port
    import dac_host_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NCOL = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_widx,
    input  logic                 load_ridx,
    input  logic                 data_wr,
    input  logic                 data_rd,
    input  logic [DW-1:0]        din,
    output logic [IDXW-1:0]      widx,
    output logic [IDXW-1:0]      ridx,
    output logic [NCOL*3*DW-1:0] colors,
    output logic [DW-1:0]        rd_byte
);

    localparam int IDXW  = (NCOL > 1) ? $clog2(NCOL) : 1;
    localparam int SLOTS = NCOL * 3;
    localparam int SW    = $clog2(SLOTS);

    logic [DW-1:0] col_q [SLOTS];
    phase_t        wphase;
    phase_t        rphase;
    logic [SW-1:0] wslot;
    logic [SW-1:0] rslot;

    assign wslot = SW'(32'(widx) * 3 + 32'(wphase));
    assign rslot = SW'(32'(ridx) * 3 + 32'(rphase));

    // write index and phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx   <= '0;
            wphase <= '0;
        end else if (load_widx) begin
            widx   <= din[IDXW-1:0];
            wphase <= '0;
        end else if (data_wr) begin
            if (wphase == PH_LAST) begin
                wphase <= '0;
                widx   <= widx + 1'b1;
            end else begin
                wphase <= wphase + 1'b1;
            end
        end
    end

    // colour byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) col_q[i] <= '0;
        end else if (data_wr && !load_widx) begin
            col_q[wslot] <= din;
        end
    end

    // read index and phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx   <= '0;
            rphase <= '0;
        end else if (load_ridx) begin
            ridx   <= din[IDXW-1:0];
            rphase <= '0;
        end else if (data_rd) begin
            if (rphase == PH_LAST) begin
                rphase <= '0;
                ridx   <= ridx + 1'b1;
            end else begin
                rphase <= rphase + 1'b1;
            end
        end
    end

    assign rd_byte = col_q[rslot];

    // flatten: colour k is {R,G,B} at bits 3*DW*k upward
    for (genvar k = 0; k < NCOL; k++) begin : g_col
        for (genvar j = 0; j < 3; j++) begin : g_byte
            assign colors[k*3*DW + (2-j)*DW +: DW] = col_q[k*3 + j];
        end
    end

endmodule

// File: rtl/dac_ctrl_file.sv
// Control, mask and cursor position registers.
// Control 3 is written only when the caller flags the gated access at the
// shared status offset. Position registers hold DW low bits and POS_W-DW
// high bits.
module dac_ctrl_file
    import dac_host_pkg::*;
#(
    parameter int DW    = 8,
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  reg_off_e         off,
    input  logic [DW-1:0]    din,
    input  logic             ext_sel,
    output logic [DW-1:0]    c0,
    output logic [DW-1:0]    c1,
    output logic [DW-1:0]    c2,
    output logic [DW-1:0]    c3,
    output logic [DW-1:0]    mask,
    output logic [POS_W-1:0] pos_x,
    output logic [POS_W-1:0] pos_y
);

    localparam int HI_W = POS_W - DW;

    logic [DW-1:0]   x_lo, y_lo;
    logic [HI_W-1:0] x_hi, y_hi;

    // decoded register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0   <= '0;
            c1   <= '0;
            c2   <= '0;
            c3   <= '0;
            mask <= '1;
            x_lo <= '0;
            x_hi <= '0;
            y_lo <= '0;
            y_hi <= '0;
        end else if (wr_stb) begin
            case (off)
                OFF_CTRL0:    c0   <= din;
                OFF_CTRL1:    c1   <= din;
                OFF_CTRL2:    c2   <= din;
                OFF_PIX_MASK: mask <= din;
                OFF_STAT_EXT: if (ext_sel) c3 <= din;
                OFF_CX_LO:    x_lo <= din;
                OFF_CX_HI:    x_hi <= din[HI_W-1:0];
                OFF_CY_LO:    y_lo <= din;
                OFF_CY_HI:    y_hi <= din[HI_W-1:0];
                default: ;
            endcase
        end
    end

    assign pos_x = {x_hi, x_lo};
    assign pos_y = {y_hi, y_lo};

endmodule

// File: rtl/dac_host_regs.sv
// Host register interface of a palette DAC.
// Decodes a 4-bit offset with separate read and write strobes, sequences
// palette and cursor colour bytes, and registers read data one cycle after
// rd_en. A read and a write in the same cycle both act; the read sees
// the pre-write state.
module dac_host_regs
    import dac_host_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PAL_AW = 8,
    parameter int NCOL   = 4,
    parameter int POS_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           reg_addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    output logic                 pal_we,
    output logic [PAL_AW-1:0]    pal_waddr,
    output logic [3*DW-1:0]      pal_wdata,
    output logic [PAL_AW-1:0]    pal_raddr,
    input  logic [3*DW-1:0]      pal_rdata,
    output logic [DW-1:0]        ctrl0,
    output logic [DW-1:0]        ctrl1,
    output logic [DW-1:0]        ctrl2,
    output logic [DW-1:0]        ctrl3,
    output logic [DW-1:0]        pix_mask,
    output logic                 clk_double,
    output logic                 cursor_64,
    output logic                 nib_swap,
    output logic [NCOL*3*DW-1:0] cur_colors,
    output logic [POS_W-1:0]     cur_x,
    output logic [POS_W-1:0]     cur_y,
    output logic                 cram_we,
    output logic [DW-1:0]        cram_wdata
);

    localparam int IDXW = (NCOL > 1) ? $clog2(NCOL) : 1;
    localparam int HI_W = POS_W - DW;

    reg_off_e        off;
    logic            ext_sel;
    phase_t          pal_rphase;
    logic [DW-1:0]   pal_byte;
    logic [DW-1:0]   cur_byte;
    logic [IDXW-1:0] cur_widx;
    logic [IDXW-1:0] cur_ridx;
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   rd_q;

    assign off     = reg_off_e'(reg_addr);
    assign ext_sel = ctrl0[EXT_GATE_BIT] && (pal_waddr == PAL_AW'(EXT_PTR_VAL));

    dac_pal_port #(.DW(DW), .AW(PAL_AW)) pal_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_wptr (wr_en && off == OFF_PAL_WPTR),
        .load_rptr (wr_en && off == OFF_PAL_RPTR),
        .data_wr   (wr_en && off == OFF_PAL_DATA),
        .data_rd   (rd_en && off == OFF_PAL_DATA),
        .din       (wr_data),
        .ram_rdata (pal_rdata),
        .wptr      (pal_waddr),
        .rptr      (pal_raddr),
        .rphase    (pal_rphase),
        .ram_we    (pal_we),
        .ram_wdata (pal_wdata),
        .rd_byte   (pal_byte)
    );

    dac_cur_port #(.DW(DW), .NCOL(NCOL)) cur_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_widx (wr_en && off == OFF_CUR_WIDX),
        .load_ridx (wr_en && off == OFF_CUR_RIDX),
        .data_wr   (wr_en && off == OFF_CUR_DATA),
        .data_rd   (rd_en && off == OFF_CUR_DATA),
        .din       (wr_data),
        .widx      (cur_widx),
        .ridx      (cur_ridx),
        .colors    (cur_colors),
        .rd_byte   (cur_byte)
    );

    dac_ctrl_file #(.DW(DW), .POS_W(POS_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_en),
        .off     (off),
        .din     (wr_data),
        .ext_sel (ext_sel),
        .c0      (ctrl0),
        .c1      (ctrl1),
        .c2      (ctrl2),
        .c3      (ctrl3),
        .mask    (pix_mask),
        .pos_x   (cur_x),
        .pos_y   (cur_y)
    );

    // read multiplexer over the current (pre-write) state
    always_comb begin
        case (off)
            OFF_PAL_WPTR: rd_mux = DW'(pal_waddr);
            OFF_PAL_DATA: rd_mux = pal_byte;
            OFF_PIX_MASK: rd_mux = pix_mask;
            OFF_PAL_RPTR: rd_mux = DW'(pal_raddr);
            OFF_CUR_WIDX: rd_mux = DW'(cur_widx);
            OFF_CUR_DATA: rd_mux = cur_byte;
            OFF_CTRL0:    rd_mux = ctrl0;
            OFF_CUR_RIDX: rd_mux = DW'(cur_ridx);
            OFF_CTRL1:    rd_mux = ctrl1;
            OFF_CTRL2:    rd_mux = ctrl2;
            OFF_STAT_EXT: rd_mux = ext_sel ? ctrl3 : DW'(pal_rphase);
            OFF_CX_LO:    rd_mux = cur_x[DW-1:0];
            OFF_CX_HI:    rd_mux = DW'(cur_x[POS_W-1 -: HI_W]);
            OFF_CY_LO:    rd_mux = cur_y[DW-1:0];
            OFF_CY_HI:    rd_mux = DW'(cur_y[POS_W-1 -: HI_W]);
            default:      rd_mux = '0;
        endcase
    end

    // read data register: loads only on rd_en
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end

    assign rd_data    = rd_q;
    assign clk_double = ctrl3[C3_CLKDBL_BIT];
    assign cursor_64  = ctrl3[C3_CUR64_BIT];
    assign nib_swap   = ctrl3[C3_NIBSWAP_BIT];
    assign cram_we    = wr_en && (off == OFF_CRAM);
    assign cram_wdata = wr_data;

endmodule

// File: rtl/dac_host_regs_chk.sv
// Protocol checker for dac_host_regs, attached by bind.
module dac_host_regs_chk #(
    parameter int DW     = 8,
    parameter int PAL_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        reg_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DW-1:0]     wr_data,
    input logic [DW-1:0]     rd_data,
    input logic              pal_we,
    input logic [PAL_AW-1:0] pal_waddr,
    input logic [DW-1:0]     ctrl0,
    input logic [DW-1:0]     ctrl3,
    input logic              cram_we
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl0 == '0 && ctrl3 == '0));

    assert_pal_we_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> (wr_en && reg_addr == 4'h1));

    assert_pal_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> (pal_waddr == PAL_AW'($past(pal_waddr) + 1'b1)));

    assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 4'h0) |=> (pal_waddr == $past(wr_data[PAL_AW-1:0])));

    assert_ctrl3_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == 4'hA && ctrl0[7] && pal_waddr == PAL_AW'(1)) |=> $stable(ctrl3));

    assert_cram_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> (wr_en && reg_addr == 4'hB));

    assert_rd_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind dac_host_regs dac_host_regs_chk #(.DW(DW), .PAL_AW(PAL_AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .pal_we    (pal_we),
    .pal_waddr (pal_waddr),
    .ctrl0     (ctrl0),
    .ctrl3     (ctrl3),
    .cram_we   (cram_we)
);

// File: tb/dac_host_regs_tb_top.sv
// Self-checking bench: full palette sweep plus targeted register cases.
module dac_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  reg_addr;
    logic        wr_en, rd_en;
    logic [7:0]  wr_data, rd_data;
    logic        pal_we;
    logic [7:0]  pal_waddr, pal_raddr;
    logic [23:0] pal_wdata, pal_rdata;
    logic [7:0]  ctrl0, ctrl1, ctrl2, ctrl3, pix_mask;
    logic        clk_double, cursor_64, nib_swap;
    logic [95:0] cur_colors;
    logic [11:0] cur_x, cur_y;
    logic        cram_we;
    logic [7:0]  cram_wdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [23:0] mem [256];

    always #10 clk = ~clk;

    // palette RAM model
    always @(posedge clk) if (pal_we) mem[pal_waddr] <= pal_wdata;
    assign pal_rdata = mem[pal_raddr];

    dac_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .pal_we(pal_we), .pal_waddr(pal_waddr),
        .pal_wdata(pal_wdata), .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
        .ctrl0(ctrl0), .ctrl1(ctrl1), .ctrl2(ctrl2), .ctrl3(ctrl3), .pix_mask(pix_mask),
        .clk_double(clk_double), .cursor_64(cursor_64), .nib_swap(nib_swap),
        .cur_colors(cur_colors), .cur_x(cur_x), .cur_y(cur_y),
        .cram_we(cram_we), .cram_wdata(cram_wdata)
    );

    function automatic logic [23:0] pat(int i);
        return {8'(i), 8'(i) ^ 8'h5A, 8'(255 - i)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        reg_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic wrd(logic [3:0] a, logic [7:0] wd, output logic [7:0] d);
        reg_addr = a; wr_data = wd; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R14 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; reg_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctrl0", 32'(ctrl0), 0);
        check("R1 ctrl1", 32'(ctrl1), 0);
        check("R1 ctrl2", 32'(ctrl2), 0);
        check("R1 ctrl3", 32'(ctrl3), 0);
        check("R1 mask", 32'(pix_mask), 32'hFF);
        rd(4'h0, v); check("R1 wptr", 32'(v), 0);
        rd(4'h3, v); check("R1 rptr", 32'(v), 0);

        // R2 full palette sweep with auto-increment
        wr(4'h0, 8'h00);
        for (int i = 0; i < 256; i++) begin
            logic [23:0] e;
            e = pat(i);
            wr(4'h1, e[23:16]); wr(4'h1, e[15:8]); wr(4'h1, e[7:0]);
        end
        for (int i = 0; i < 256; i++) check("R2 entry", 32'(mem[i]), 32'(pat(i)));
        rd(4'h0, v); check("R2 pointer wrap", 32'(v), 0);

        // R4 read sweep
        wr(4'h3, 8'h00);
        for (int i = 0; i < 256; i++) begin
            logic [23:0] e;
            e = pat(i);
            rd(4'h1, v); check("R4 red", 32'(v), 32'(e[23:16]));
            rd(4'h1, v); check("R4 green", 32'(v), 32'(e[15:8]));
            rd(4'h1, v); check("R4 blue", 32'(v), 32'(e[7:0]));
        end

        // R3 reload mid-triplet
        wr(4'h0, 8'd10); wr(4'h1, 8'h01); wr(4'h1, 8'h02);
        wr(4'h0, 8'd20); wr(4'h1, 8'hAA); wr(4'h1, 8'hBB); wr(4'h1, 8'hCC);
        check("R3 new entry", 32'(mem[20]), 32'hAABBCC);
        check("R3 old entry untouched", 32'(mem[10]), 32'(pat(10)));
        rd(4'h0, v); check("R3 pointer", 32'(v), 21);

        // R5 same-cycle load and read of read pointer
        wr(4'h3, 8'd5);
        rd(4'h1, v); check("R5 setup red", 32'(v), 32'(pat(5) >> 16));
        wrd(4'h3, 8'd9, v); check("R5 old pointer", 32'(v), 5);
        rd(4'h1, v); check("R5 load restarts at red", 32'(v), 32'(pat(9) >> 16));
        // R5 same-cycle write and read of data port
        wr(4'h0, 8'd30); wr(4'h3, 8'd30);
        wrd(4'h1, 8'h77, v); check("R5 read old red", 32'(v), 32'(pat(30) >> 16));
        wr(4'h1, 8'h78); wr(4'h1, 8'h79);
        check("R5 write completed", 32'(mem[30]), 32'h777879);
        rd(4'h1, v); check("R5 read after write", 32'(v), 32'h78);

        // R6 control and mask read-back, read-modify-write
        wr(4'h2, 8'h0F); rd(4'h2, v); check("R6 mask", 32'(v), 32'h0F);
        check("R6 mask port", 32'(pix_mask), 32'h0F);
        wr(4'h8, 8'h55); rd(4'h8, v); check("R6 ctrl1", 32'(v), 32'h55);
        wr(4'h9, 8'h20); rd(4'h9, v); wr(4'h9, v | 8'h03);
        rd(4'h9, v); check("R6 ctrl2 rmw", 32'(v), 32'h23);
        check("R6 ctrl2 port", 32'(ctrl2), 32'h23);

        // R7 / R9 gated control 3
        wr(4'h6, 8'h80); wr(4'h0, 8'h01); wr(4'hA, 8'h1C);
        rd(4'hA, v); check("R7 ctrl3 read", 32'(v), 32'h1C);
        check("R9 clk_double", 32'(clk_double), 1);
        check("R9 cursor_64", 32'(cursor_64), 1);
        check("R9 nib_swap", 32'(nib_swap), 1);
        wr(4'hA, 8'h08);
        check("R9 nib_swap clear", 32'(nib_swap), 0);
        check("R9 cursor_64 clear", 32'(cursor_64), 0);
        check("R9 clk_double set", 32'(clk_double), 1);

        // R8 writes outside the gate are ignored
        wr(4'h0, 8'h02); wr(4'hA, 8'hFF); wr(4'h0, 8'h01);
        rd(4'hA, v); check("R8 wrong pointer ignored", 32'(v), 32'h08);
        wr(4'h6, 8'h00); wr(4'hA, 8'hFF);
        check("R8 gate closed port", 32'(ctrl3), 32'h08);
        wr(4'h6, 8'h80); rd(4'hA, v); check("R8 gate closed ignored", 32'(v), 32'h08);
        wr(4'h6, 8'h00); wr(4'h3, 8'h00); rd(4'h1, v);
        rd(4'hA, v); check("R8 status phase", 32'(v), 1);

        // R10 cursor colour stream
        wr(4'h4, 8'h00);
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 3; b++) wr(4'h5, 8'(16 * k + b + 1));
        for (int k = 0; k < 4; k++)
            check("R10 colour", 32'(cur_colors[24*k +: 24]),
                  32'({8'(16*k+1), 8'(16*k+2), 8'(16*k+3)}));
        rd(4'h4, v); check("R10 index wrap", 32'(v), 0);

        // R11 cursor colour read
        wr(4'h7, 8'h02);
        rd(4'h5, v); check("R11 red", 32'(v), 32'h21);
        rd(4'h5, v); check("R11 green", 32'(v), 32'h22);
        rd(4'h5, v); check("R11 blue", 32'(v), 32'h23);
        rd(4'h5, v); check("R11 next colour", 32'(v), 32'h31);

        // R12 cursor position
        wr(4'hC, 8'h34); wr(4'hD, 8'hF5);
        check("R12 x", 32'(cur_x), 32'h534);
        rd(4'hD, v); check("R12 x high read", 32'(v), 32'h05);
        wr(4'hE, 8'h12); wr(4'hF, 8'hAB);
        check("R12 y", 32'(cur_y), 32'hB12);

        // R13 cursor RAM strobe in the write cycle
        reg_addr = 4'hB; wr_data = 8'h3C; wr_en = 1'b1;
        #1;
        check("R13 strobe", 32'(cram_we), 1);
        check("R13 data", 32'(cram_wdata), 32'h3C);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R13 idle", 32'(cram_we), 0);
        reg_addr = 4'hC; wr_en = 1'b1; #1;
        check("R13 other offset", 32'(cram_we), 0);
        @(negedge clk); wr_en = 1'b0;

        // R14 read data holds without rd_en
        rd(4'h8, held);
        wr(4'h8, 8'h99);
        repeat (3) @(negedge clk);
        check("R14 hold", 32'(rd_data), 32'(held));
        rd(4'h8, v); check("R14 update", 32'(v), 32'h99);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule